// File: doc/BRIEF.md
# Low-Power Entry Gating Register

This block is a small memory-mapped control register that sits between the processor core and the power controller. The core signals with a one-cycle pulse each time it executes a stop or a wait instruction. The block turns that pulse into a mode-entry request only if software has left the matching gate open. Each instruction has its own 2-bit gate field. A gate can be open, shut but still writable, or shut and frozen until the next device reset. The register also gives software a way to ask for a whole-chip reset, through a trigger bit that is never stored.

The stop gate sits in bits 3..2 and the wait gate in bits 1..0 of the register at address `CTRL_ADDR`. Each gate keeps a sticky lock flag of its own, so freezing one gate leaves the other free. Reads are combinational on the address. All state is cleared by an asynchronous active-low reset.

Top module: `lpm_gate_ctrl`

## Requirements
- R1: A read at `CTRL_ADDR` returns the stop gate in bits 3..2 and the wait gate in bits 1..0. Bit 4 and every bit above it read as 0.
- R2: After reset both gates hold 00 and neither is locked, so the register reads 0x0000 and entry is allowed.
- R3: When the stop gate holds 00, a pulse on `stop_exec` raises `stop_enter` for exactly the following clock cycle. Any other gate value keeps `stop_enter` low.
- R4: Writing 01 to a gate that is not locked blocks entry. The gate can be rewritten afterwards, including back to 00.
- R5: Writing 10 or 11 to the unlocked stop gate blocks stop entry and locks the gate. Later writes to the stop gate have no effect until reset.
- R6: When the wait gate holds 00, a pulse on `wait_exec` raises `wait_enter` for exactly the following clock cycle. Any other gate value keeps `wait_enter` low.
- R7: Writing 10 or 11 to the unlocked wait gate blocks wait entry and locks the gate until reset.
- R8: A write at `CTRL_ADDR` with bit 4 set drives `sw_reset_req` high for exactly the one cycle after the write. The bit is not stored.
- R9: A write at any other address changes no gate and raises no reset request. Reads at any other address return 0.
- R10: The two gates lock independently. While one gate is locked, the other still accepts writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | ADDR_W | Register address |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr` |
| stop_exec | input | 1 | Pulse: core executed a stop instruction |
| wait_exec | input | 1 | Pulse: core executed a wait instruction |
| stop_enter | output | 1 | One-cycle request to enter stop mode |
| wait_enter | output | 1 | One-cycle request to enter wait mode |
| sw_reset_req | output | 1 | One-cycle request for a chip reset |

## Verification
The assertions assume three things about the inputs:
- `bus_we` is a single-cycle strobe.
- The instruction pulses are sampled on the same clock as the register.
- Nothing relies on a write and an execute pulse in the same cycle. In that cycle the gate value from before the write decides.

The stimulus drives every input on the falling edge. It never overlaps a write with an execute pulse, and it returns `bus_we` and both execute lines low after each operation. Every checked output is therefore the result of exactly one isolated action.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

  localparam int unsigned GATE_W = 2;

  typedef enum logic [GATE_W-1:0] {
    GATE_OPEN    = 2'b00,
    GATE_SHUT    = 2'b01,
    GATE_FREEZE  = 2'b10,
    GATE_FREEZE2 = 2'b11
  } gate_mode_e;

  // entry is permitted only for the open code
  function automatic logic gate_permits(input logic [GATE_W-1:0] v);
    return (v == GATE_OPEN);
  endfunction

  // any code with the upper bit set freezes the field
  function automatic logic gate_freezes(input logic [GATE_W-1:0] v);
    return v[GATE_W-1];
  endfunction

  // index 0 = wait gate, index 1 = stop gate
  function automatic int unsigned gate_lsb(input int unsigned idx);
    return idx * GATE_W;
  endfunction

endpackage

// File: rtl/lpm_gate_field.sv
module lpm_gate_field
  import lpm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [GATE_W-1:0] wr_val,
  input  logic              exec_i,
  output logic [GATE_W-1:0] val_o,
  output logic              locked_o,
  output logic              enter_o
);

  logic [GATE_W-1:0] val_q;
  logic              lock_q;
  logic              enter_q;
  logic              wr_take;
  logic              lock_set;
  logic              enter_now;

  assign wr_take   = wr_en && !lock_q;
  assign lock_set  = wr_take && gate_freezes(wr_val);
  assign enter_now = exec_i && gate_permits(val_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q   <= GATE_OPEN;
      lock_q  <= 1'b0;
      enter_q <= 1'b0;
    end else begin
      if (wr_take) val_q <= wr_val;
      if (lock_set) lock_q <= 1'b1;
      enter_q <= enter_now;
    end
  end

  assign val_o    = val_q;
  assign locked_o = lock_q;
  assign enter_o  = enter_q;

  // R3
  enter_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    enter_q |-> ($past(exec_i) && ($past(val_q) == GATE_OPEN)));

  // R4
  write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !lock_q) |=> (val_q == $past(wr_val)));

  // R5
  frozen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> $stable(val_q));

  // R7
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> lock_q);

endmodule

// File: rtl/lpm_swrst_pulse.sv
module lpm_swrst_pulse #(
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned TRIG_BIT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hit,
  input  logic [DATA_W-1:0] wdata,
  output logic              pulse_o
);

  logic trig_now;
  logic pulse_q;

  assign trig_now = wr_hit && wdata[TRIG_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse_q <= 1'b0;
    else        pulse_q <= trig_now;
  end

  assign pulse_o = pulse_q;

  // R8
  pulse_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |-> $past(wr_hit && wdata[TRIG_BIT]));

  // R8
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_q && !$past(trig_now, 1) ) |-> 1'b0);

endmodule

// File: rtl/lpm_gate_ctrl.sv
module lpm_gate_ctrl
  import lpm_pkg::*;
#(
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned CTRL_ADDR = 0,
  parameter int unsigned TRIG_BIT  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              stop_exec,
  input  logic              wait_exec,
  output logic              stop_enter,
  output logic              wait_enter,
  output logic              sw_reset_req
);

  localparam int unsigned NUM_GATES = 2;
  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);

  logic                               addr_hit;
  logic                               wr_hit;
  logic [NUM_GATES-1:0]               exec_vec;
  logic [NUM_GATES-1:0]               enter_vec;
  logic [NUM_GATES-1:0]               lock_vec;
  logic [NUM_GATES-1:0][GATE_W-1:0]   gate_val;
  logic [DATA_W-1:0]                  rd_image;

  assign addr_hit = (bus_addr == CTRL_A);
  assign wr_hit   = bus_we && addr_hit;
  assign exec_vec = {stop_exec, wait_exec};

  for (genvar g = 0; g < NUM_GATES; g++) begin : g_gate
    lpm_gate_field u_fld (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_hit),
      .wr_val   (bus_wdata[gate_lsb(g) +: GATE_W]),
      .exec_i   (exec_vec[g]),
      .val_o    (gate_val[g]),
      .locked_o (lock_vec[g]),
      .enter_o  (enter_vec[g])
    );
  end

  always_comb begin
    rd_image = '0;
    for (int i = 0; i < NUM_GATES; i++) begin
      rd_image[gate_lsb(i) +: GATE_W] = gate_val[i];
    end
  end

  assign bus_rdata  = addr_hit ? rd_image : '0;
  assign wait_enter = enter_vec[0];
  assign stop_enter = enter_vec[1];

  lpm_swrst_pulse #(
    .DATA_W   (DATA_W),
    .TRIG_BIT (TRIG_BIT)
  ) u_swrst (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_hit  (wr_hit),
    .wdata   (bus_wdata),
    .pulse_o (sw_reset_req)
  );

  // R10
  lock_split_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && lock_vec[1] && !lock_vec[0]) |=>
      (gate_val[0] == $past(bus_wdata[gate_lsb(0) +: GATE_W])));

  // R9
  stray_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && !addr_hit) |=> (!sw_reset_req && $stable(gate_val)));

endmodule

// File: tb/lpm_gate_ctrl_tb.sv
module lpm_gate_ctrl_tb_top;

  localparam int unsigned AW = 4;
  localparam int unsigned DW = 16;
  localparam int NV = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic          bus_we = 1'b0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic          stop_exec = 1'b0;
  logic          wait_exec = 1'b0;
  logic          stop_enter;
  logic          wait_enter;
  logic          sw_reset_req;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  lpm_gate_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .stop_exec(stop_exec),
    .wait_exec(wait_exec), .stop_enter(stop_enter), .wait_enter(wait_enter),
    .sw_reset_req(sw_reset_req)
  );

  // {do_write, wdata, expected read, expected stop_enter, expected wait_enter}
  localparam logic [34:0] VEC [NV] = '{
    {1'b0, 16'h0000, 16'h0000, 1'b1, 1'b1},  // R2 reset state, R3 R6 open
    {1'b1, 16'h0005, 16'h0005, 1'b0, 1'b0},  // R4 both shut
    {1'b1, 16'h0000, 16'h0000, 1'b1, 1'b1},  // R4 reopen
    {1'b1, 16'h0009, 16'h0009, 1'b0, 1'b0},  // R5 stop frozen, wait shut
    {1'b1, 16'h0000, 16'h0008, 1'b0, 1'b1},  // R5 R10 stop ignores, wait opens
    {1'b1, 16'h0003, 16'h000B, 1'b0, 1'b0},  // R7 wait frozen with 11
    {1'b1, 16'h0000, 16'h000B, 1'b0, 1'b0},  // R7 both frozen
    {1'b1, 16'hFFE0, 16'h000B, 1'b0, 1'b0}   // R1 upper bits not stored
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
  endtask

  task automatic pulse_exec(output logic st, output logic wt);
    @(negedge clk);
    stop_exec = 1'b1; wait_exec = 1'b1;
    @(negedge clk);
    stop_exec = 1'b0; wait_exec = 1'b0;
    st = stop_enter; wt = wait_enter;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    logic st, wt;
    do_reset();
    @(negedge clk);
    check("R2 rdata", 32'(bus_rdata), 32'h0);
    check("R2 idle enters", {30'b0, stop_enter, wait_enter}, 32'h0);
    check("R8 idle reset req", 32'(sw_reset_req), 32'h0);

    for (int v = 0; v < NV; v++) begin
      if (VEC[v][34]) bus_write('0, VEC[v][33:18]);
      @(negedge clk);
      check($sformatf("R1 vec%0d rdata", v), 32'(bus_rdata), 32'(VEC[v][17:2]));
      pulse_exec(st, wt);
      check($sformatf("R3 vec%0d stop_enter", v), 32'(st), 32'(VEC[v][1]));
      check($sformatf("R6 vec%0d wait_enter", v), 32'(wt), 32'(VEC[v][0]));
      @(negedge clk);
      check($sformatf("R3 R6 vec%0d one cycle", v), {30'b0, stop_enter, wait_enter}, 32'h0);
    end

    // R2: reset clears locks
    do_reset();
    @(negedge clk);
    check("R2 after relock reset", 32'(bus_rdata), 32'h0);

    // R8: reset trigger pulse, not stored
    @(negedge clk);
    bus_addr = '0; bus_wdata = 16'h0014; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0;
    check("R8 pulse high", 32'(sw_reset_req), 32'h1);
    check("R1 R8 bit4 reads 0", 32'(bus_rdata), 32'h0004);
    @(negedge clk);
    check("R8 pulse low", 32'(sw_reset_req), 32'h0);

    // R9: other address
    bus_write(4'h1, 16'h001F);
    check("R9 no reset req", 32'(sw_reset_req), 32'h0);
    bus_addr = 4'h1;
    @(negedge clk);
    check("R9 other reads 0", 32'(bus_rdata), 32'h0);
    bus_addr = '0;
    @(negedge clk);
    check("R9 gates unchanged", 32'(bus_rdata), 32'h0004);

    // R5: stop frozen with 11, wait still writable (R10)
    bus_write('0, 16'h000C);
    bus_write('0, 16'h0001);
    @(negedge clk);
    check("R5 R10 stop 11 frozen wait writable", 32'(bus_rdata), 32'h000D);
    pulse_exec(st, wt);
    check("R5 stop blocked", 32'(st), 32'h0);
    check("R4 wait shut", 32'(wt), 32'h0);

    // R7: wait frozen with 10
    do_reset();
    bus_write('0, 16'h0002);
    bus_write('0, 16'h0000);
    @(negedge clk);
    check("R7 wait 10 frozen", 32'(bus_rdata), 32'h0002);
    pulse_exec(st, wt);
    check("R7 wait blocked", 32'(wt), 32'h0);
    check("R10 stop open", 32'(st), 32'h1);

    finish_run();
  end

endmodule